// File: doc/BRIEF.md
# Compare-Match System Timer

This block keeps a wide free-running up-counter that advances on a tick-enable input, and several compare channels that watch the low word of that counter. When the counter steps onto a channel's compare value, the channel's match flag rises and drives that channel's interrupt line. Software clears a flag by writing one to its bit in a shared control/status word. Compare values are never advanced by the hardware. A channel therefore fires again only after the low word of the counter has gone through a full wrap back to the same value.

Software reaches the block through a simple word-addressed register port. Writes take one cycle. Read data is a combinational function of the address. The counter can be read but not written, as a low word and a high word. The block does not divide or generate ticks. Channels are not reloaded automatically, and no mask sits between a flag and its interrupt line.

Top module: `cmp_systimer`

## Requirements
- R1: After a synchronous active-low reset, the counter, every compare register and every match flag read zero, and every irq bit is low.
- R2: The counter rises by exactly one at each clock edge where tick_en is high and holds its value otherwise.
- R3: Address 0x04 reads the low LO_W bits of the counter and address 0x08 reads the upper CNT_W-LO_W bits, both zero-extended to the data width.
- R4: Channel i's compare register is written and read back at address 0x0C + 4*i, taking the low LO_W bits of the write data.
- R5: Channel i's match flag is set at the clock edge where a tick moves the counter's low word onto channel i's compare value.
- R6: A counter that stays on a channel's compare value without ticking never sets that channel's flag again after it has been cleared.
- R7: Address 0x00 reads the match flags in bits 0 to NCH-1 (bit i for channel i). A write to it clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R8: When a clear write and a new match for the same channel fall on the same edge, the flag ends up set.
- R9: irq[i] always equals channel i's match flag. No control bit masks it.
- R10: A compare register keeps its value after a match, so a channel fires again exactly 2^LO_W ticks after its previous match.
- R11: Writes to the counter addresses 0x04 and 0x08 leave the counter unchanged. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable, one step per high cycle |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel interrupt, equal to the match flag |

## Verification
The bench builds the block with a 16-bit counter, an 8-bit low word and four channels. With an 8-bit low word, a full wrap takes only 256 ticks, so a few thousand cycles reach repeat firing after a wrap, carries into the high word, and frequent random matches on all four channels. The default 64-bit counter with 32-bit compares would put all of these out of reach of any simulation.

// File: rtl/systimer_pkg.sv
// Package: shared register offsets for the compare-match system timer.
// Assumes byte addressing with word-aligned registers.
package systimer_pkg;

    localparam int OFS_CTRL    = 'h00;  // match flags, write one to clear
    localparam int OFS_CNT_LO  = 'h04;  // counter low word (read only)
    localparam int OFS_CNT_HI  = 'h08;  // counter high word (read only)
    localparam int OFS_CMP_0   = 'h0C;  // first compare channel
    localparam int CMP_STRIDE  = 4;     // byte spacing of compare channels

    // Byte offset of compare channel idx.
    function automatic int cmp_ofs(input int idx);
        return OFS_CMP_0 + CMP_STRIDE * idx;
    endfunction

endpackage

// File: rtl/systimer_counter.sv
// Module: free-running up-counter.
// Steps by one on each cycle with tick high and wraps at full width.
// Also gives the low word the counter will have after the next tick, so
// channels can catch the step onto their compare value.
// Assumes 0 < LO_W < CNT_W.
module systimer_counter #(
    parameter int CNT_W = 64,
    parameter int LO_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic [LO_W-1:0]  nxt_lo
);

    // Counter register: clears on reset, advances on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Low word after the coming tick.
    always_comb begin
        nxt_lo = cnt[LO_W-1:0] + LO_W'(1);
    end

    // R2: a tick advances the count by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R2: without a tick the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/systimer_channel.sv
// Module: one compare channel.
// Holds a compare value and a match flag. The flag sets when a tick moves
// the counter low word onto the compare value. A clear request drops the
// flag unless a match arrives on the same edge. The compare value changes
// only on a write.
module systimer_channel #(
    parameter int LO_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [LO_W-1:0] nxt_lo,
    input  logic            cmp_we,
    input  logic [LO_W-1:0] cmp_wval,
    input  logic            clr,
    output logic [LO_W-1:0] cmp,
    output logic            flag
);

    logic hit;

    // Match event: this tick lands the counter on the compare value.
    always_comb begin
        hit = tick && (nxt_lo == cmp);
    end

    // Compare register: loaded only by a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (cmp_we) begin
            cmp <= cmp_wval;
        end
    end

    // Match flag: a match has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R5: a match event raises the flag
    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R6: no tick, no rise of the flag
    a_r6_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flag) |=> !flag);

    // R7: a clear without a match drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);

    // R8: a match on the same edge as a clear keeps the flag
    a_r8_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit) |=> flag);

    // R10: without a write the compare value never moves
    a_r10_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_we |=> $stable(cmp));

endmodule

// File: rtl/systimer_regif.sv
// Module: register decode and read multiplexer.
// Turns a write at a compare address into that channel's load strobe, and a
// write at the control address into per-channel clear requests (one per data
// bit set). Read data is combinational from the address. Counter addresses
// are read only, and unmapped addresses read zero.
// Assumes NCH <= LO_W, LO_W <= DATA_W and CNT_W - LO_W <= DATA_W.
module systimer_regif
    import systimer_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 64,
    parameter int LO_W   = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                      addr_valid_unused,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [CNT_W-1:0]          cnt,
    input  logic [NCH-1:0][LO_W-1:0]  cmp,
    input  logic [NCH-1:0]            flags,
    output logic [NCH-1:0]            cmp_we,
    output logic [LO_W-1:0]           cmp_wval,
    output logic [NCH-1:0]            clr,
    output logic [DATA_W-1:0]         rdata
);

    localparam int HI_W = CNT_W - LO_W;

    logic sel_ctrl;
    logic sel_lo;
    logic sel_hi;

    // Fixed-address selects.
    always_comb begin
        sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
        sel_lo   = (addr == ADDR_W'(OFS_CNT_LO));
        sel_hi   = (addr == ADDR_W'(OFS_CNT_HI));
    end

    // Compare write value: low word of the bus data.
    always_comb begin
        cmp_wval = wdata[LO_W-1:0];
    end

    // Per-channel write strobes and clear requests.
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_dec
            always_comb begin
                cmp_we[g] = wr && (addr == ADDR_W'(cmp_ofs(g)));
                clr[g]    = wr && sel_ctrl && wdata[g];
            end
        end
    endgenerate

    // Read multiplexer, zero-extended, zero on unmapped addresses.
    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[NCH-1:0] = flags;
        end else if (sel_lo) begin
            rdata[LO_W-1:0] = cnt[LO_W-1:0];
        end else if (sel_hi) begin
            rdata[HI_W-1:0] = cnt[CNT_W-1:LO_W];
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == ADDR_W'(cmp_ofs(i))) begin
                    rdata[LO_W-1:0] = cmp[i];
                end
            end
        end
    end

    // Write data bits above the low word carry nothing.
    generate
        if (LO_W < DATA_W) begin : g_wide_bus
            logic unused_wdata_hi;
            always_comb begin
                unused_wdata_hi = ^wdata[DATA_W-1:LO_W] ^ addr_valid_unused;
            end
        end else begin : g_exact_bus
            logic unused_tie;
            always_comb begin
                unused_tie = addr_valid_unused;
            end
        end
    endgenerate

endmodule

// File: rtl/cmp_systimer.sv
// Module: compare-match system timer, top level.
// A free-running counter advanced by tick_en, NCH compare channels watching
// its low word, and a register port. Each irq bit follows its channel's
// match flag directly.
// Assumes tick generation happens elsewhere and bus_rdata is sampled in the
// same cycle as bus_addr.
module cmp_systimer #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 64,
    parameter int LO_W   = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);

    logic [CNT_W-1:0]         cnt;
    logic [LO_W-1:0]          nxt_lo;
    logic [NCH-1:0][LO_W-1:0] cmp;
    logic [NCH-1:0]           flags;
    logic [NCH-1:0]           cmp_we;
    logic [NCH-1:0]           clr;
    logic [LO_W-1:0]          cmp_wval;

    systimer_counter #(
        .CNT_W (CNT_W),
        .LO_W  (LO_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .cnt    (cnt),
        .nxt_lo (nxt_lo)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            systimer_channel #(
                .LO_W (LO_W)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick_en),
                .nxt_lo   (nxt_lo),
                .cmp_we   (cmp_we[g]),
                .cmp_wval (cmp_wval),
                .clr      (clr[g]),
                .cmp      (cmp[g]),
                .flag     (flags[g])
            );
        end
    endgenerate

    systimer_regif #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .LO_W   (LO_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .addr_valid_unused (1'b0),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .cmp      (cmp),
        .flags    (flags),
        .cmp_we   (cmp_we),
        .cmp_wval (cmp_wval),
        .clr      (clr),
        .rdata    (bus_rdata)
    );

    // Interrupt lines: one per flag, no masking.
    always_comb begin
        irq = flags;
    end

    // R11: a counter-address write without a tick leaves the count alone
    a_r11_cnt_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !tick_en && (bus_addr == ADDR_W'(systimer_pkg::OFS_CNT_LO)))
        |=> $stable(cnt));

endmodule

// File: tb/cmp_systimer_tb.sv
`timescale 1ns/1ps
module cmp_systimer_tb;

    localparam int NCH    = 4;
    localparam int CNT_W  = 16;
    localparam int LO_W   = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam real TCK   = 4.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCH-1:0]    irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference state
    logic [CNT_W-1:0] m_cnt;
    logic [LO_W-1:0]  m_cmp [NCH];
    logic [NCH-1:0]   m_flag;

    always #(TCK/2) clk = ~clk;

    cmp_systimer #(
        .NCH(NCH), .CNT_W(CNT_W), .LO_W(LO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] r;
        r = '0;
        if (a == 5'h00) r[NCH-1:0] = m_flag;
        else if (a == 5'h04) r[LO_W-1:0] = m_cnt[LO_W-1:0];
        else if (a == 5'h08) r[CNT_W-LO_W-1:0] = m_cnt[CNT_W-1:LO_W];
        else begin
            for (int i = 0; i < NCH; i++)
                if (int'(a) == 12 + 4*i) r[LO_W-1:0] = m_cmp[i];
        end
        return r;
    endfunction

    task automatic model_reset();
        m_cnt  = '0;
        m_flag = '0;
        for (int i = 0; i < NCH; i++) m_cmp[i] = '0;
    endtask

    // Next state of the reference after one clock edge.
    task automatic model_step(input logic t, input logic w,
                              input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        logic [LO_W-1:0] nlo;
        nlo = m_cnt[LO_W-1:0] + 8'd1;
        for (int i = 0; i < NCH; i++) begin
            if (t && nlo == m_cmp[i]) m_flag[i] = 1'b1;
            else if (w && a == 5'h00 && d[i]) m_flag[i] = 1'b0;
        end
        for (int i = 0; i < NCH; i++)
            if (w && int'(a) == 12 + 4*i) m_cmp[i] = d[LO_W-1:0];
        if (t) m_cnt = m_cnt + 16'd1;
    endtask

    task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, check read data and irq against current state, advance.
    task automatic cyc(input logic t, input logic w, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input string tag);
        @(negedge clk);
        tick_en = t; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        chk(bus_rdata, exp_read(a), tag);
        chk({28'b0, irq}, {28'b0, m_flag}, "R9 irq follows flag");
        model_step(t, w, a, d);
    endtask

    initial begin
        logic [LO_W-1:0] c;
        void'($urandom(32'h5EED_0042));
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        cyc(0, 0, 5'h00, 0, "R1 flags after reset");
        cyc(0, 0, 5'h04, 0, "R1 counter low after reset");
        cyc(0, 0, 5'h08, 0, "R1 counter high after reset");
        for (int i = 0; i < NCH; i++) cyc(0, 0, 5'(12 + 4*i), 0, "R1 compare after reset");

        // R4: compare write and readback
        cyc(0, 1, 5'h10, 32'hFFFF_FF05, "R4 write cmp1");
        cyc(0, 0, 5'h10, 0, "R4 readback cmp1");
        chk(bus_rdata, 32'h05, "R4 cmp1 value");

        // R2 and R5: tick to 5 with gaps, flag 1 sets on the step onto 5
        cyc(1, 0, 5'h04, 0, "R2 count");
        cyc(0, 0, 5'h04, 0, "R2 hold");
        cyc(1, 0, 5'h04, 0, "R2 count");
        cyc(1, 0, 5'h04, 0, "R2 count");
        cyc(1, 0, 5'h00, 0, "R5 no flag before match");
        cyc(1, 0, 5'h00, 0, "R5 no flag before match");
        cyc(0, 0, 5'h00, 0, "R5 flag after match");
        chk(bus_rdata, 32'h2, "R5 flag1 set");

        // R7: write of zeros and of other bits leaves flag 1 set
        cyc(0, 1, 5'h00, 32'h0, "R7 write zero");
        cyc(0, 1, 5'h00, 32'hD, "R7 write other bits");
        cyc(0, 0, 5'h00, 0, "R7 flag1 still set");
        chk(bus_rdata, 32'h2, "R7 flag1 kept");

        // R6: clear with the counter parked on the compare value
        cyc(0, 1, 5'h00, 32'h2, "R6 clear flag1");
        for (int k = 0; k < 4; k++) cyc(0, 0, 5'h00, 0, "R6 flag stays clear");
        chk(bus_rdata, 32'h0, "R6 flag1 clear");

        // R8: clear on the same edge as a new match on channel 2
        c = m_cnt[LO_W-1:0] + 8'd2;
        cyc(0, 1, 5'h14, {24'b0, c}, "R8 write cmp2");
        cyc(1, 0, 5'h00, 0, "R8 approach");
        cyc(1, 1, 5'h00, 32'h4, "R8 clear with match");
        cyc(0, 0, 5'h00, 0, "R8 flag2 survives");
        chk(bus_rdata, 32'h4, "R8 flag2 set");
        cyc(0, 1, 5'h00, 32'hF, "R7 clear all");

        // R10: channel 1 fires again after a full low-word wrap
        for (int k = 0; k < 256; k++) cyc(1, 0, 5'h00, 0, "R10 wrap refire");
        cyc(0, 0, 5'h00, 0, "R10 flag after wrap");
        chk(bus_rdata[1], 1'b1, "R10 flag1 set again");
        cyc(0, 0, 5'h10, 0, "R10 compare unchanged");

        // R3: high word after the wrap
        cyc(0, 0, 5'h08, 0, "R3 high word");
        chk(bus_rdata, 32'h1, "R3 high word is one");

        // R11: counter is read only, unmapped reads zero
        cyc(0, 1, 5'h04, 32'hAB, "R11 write low");
        cyc(0, 1, 5'h08, 32'hCD, "R11 write high");
        cyc(0, 0, 5'h04, 0, "R11 low unchanged");
        cyc(0, 0, 5'h08, 0, "R11 high unchanged");
        cyc(0, 0, 5'h1C, 0, "R11 unmapped zero");
        cyc(0, 0, 5'h06, 0, "R11 unaligned zero");

        // random mix against the reference
        for (int k = 0; k < 3000; k++) begin
            logic t, w;
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            int sel;
            t = ($urandom % 2) == 0;
            w = ($urandom % 4) == 0;
            sel = $urandom % 8;
            a = (sel < 7) ? 5'(4 * sel) : 5'($urandom);
            d = $urandom;
            cyc(t, w, a, d, "R5 R7 R10 random");
        end
        cyc(0, 0, 5'h00, 0, "R7 final flags");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule